// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a program sequencer and runs hardware loops without any overhead instructions. The fetch stage reports every fetched address. When it fetches a loop-start command, it also supplies the address of the last body instruction and a termination condition. The body begins at the address after the command. From then on the controller compares each fetch address with the end address of the innermost loop. On a match it evaluates the termination condition in the same cycle. It then tells the fetch stage either to redirect to the loop top or to carry on sequentially. No branch, compare or decrement instruction is ever issued by software.

A loop terminates in one of two ways. The first is a counter-expired condition that uses an iteration count written beforehand through a count-load strobe. The second is an ordinary arithmetic status condition (equal, less-than, greater-than and the like) built from the zero and negative flags. Loops nest through an internal stack. Each level keeps its top address, end address, condition and the enclosing loop's count, so an inner loop that exits hands the outer count back intact.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the stack is empty (`stk_empty`=1, `stk_full`=0, `loop_depth`=0), `stk_ovf`=0, `loop_active`=0, `pc_sel`=0 and `cur_count`=0.
- R2: A loop-start command accepted at fetch address A pushes a level. Its top address is A+1. `loop_depth` rises by one on the next clock, `loop_active` becomes 1, and `cur_count` takes the value most recently written by `cnt_load`.
- R3: Condition code 0 (counter-expired) with `cur_count` above 1: when the fetch address equals the innermost end address, `pc_sel`=1 with `pc_target` equal to the loop top in that same cycle. `cur_count` then drops by exactly one on the next clock.
- R4: Condition code 0 with `cur_count` of 1 or 0: at the end address `pc_sel`=0, the level is popped, and `cur_count` reverts to the enclosing loop's count. A loaded count of 0 therefore runs the body once.
- R5: Flag conditions use flags[0]=zero and flags[1]=negative, sampled in the end-address cycle. The codes are 1 EQ (zero), 2 NE (not zero), 3 LT (negative), 4 GE (not negative), 5 GT (neither), 6 LE (either) and 7 never. A false condition redirects and leaves `cur_count` unchanged. A true one falls through and pops.
- R6: At any fetch address that is not the innermost end address, `pc_sel`=0.
- R7: A count of 30 with a three-instruction body executes the body exactly 30 times. Fetch then continues at the address after the end address.
- R8: Loops nest up to DEPTH (default 6) levels, and `stk_full`=1 exactly when DEPTH levels are held. An inner loop runs its full count on every pass of the outer one.
- R9: A loop-start command while the stack is full leaves the depth, the count and all held levels unchanged, and sets the sticky `stk_ovf`. Only reset clears `stk_ovf`.
- R10: A loop-start command fetched at the innermost end address is ignored. The end-address handling alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | AW | Address fetched in this cycle |
| start_cmd | input | 1 | The fetched word is a loop-start command |
| start_end | input | AW | Last body address carried by the command |
| start_cond | input | 3 | Termination condition code carried by the command |
| cnt_load | input | 1 | Write `cnt_value` into the pending count |
| cnt_value | input | CW | Iteration count for the next loop |
| flags | input | 2 | Arithmetic status: [0] zero, [1] negative |
| pc_sel | output | 1 | 1 = next PC is `pc_target`, 0 = sequential |
| pc_target | output | AW | Top address of the innermost loop |
| loop_active | output | 1 | At least one loop is running |
| cur_count | output | CW | Count of the innermost loop |
| loop_depth | output | SPW | Number of held levels |
| stk_empty | output | 1 | No level held |
| stk_full | output | 1 | DEPTH levels held |
| stk_ovf | output | 1 | Sticky: a start was refused on a full stack |

## Verification
A wrong stack pointer or a corrupted level shows up as a wrong `pc_sel` or `pc_target` the next time the innermost end address is fetched. It also shows up at once in `loop_depth` and the full and empty flags. A count that is not decremented or not restored shows up in `cur_count` one clock after the end-address cycle. Its effect on control flow appears one body length later, as an extra or a missing pass. The bench moves the fetch address the way a real sequencer would and compares every output in every cycle. A divergence is therefore reported in the cycle it appears, not at the end of the run.

// File: rtl/hwloop_pkg.sv
// Shared definitions for the hardware loop controller.
package hwloop_pkg;
    // Termination condition codes carried by a loop-start command.
    typedef enum logic [2:0] {
        COND_LCE   = 3'd0,
        COND_EQ    = 3'd1,
        COND_NE    = 3'd2,
        COND_LT    = 3'd3,
        COND_GE    = 3'd4,
        COND_GT    = 3'd5,
        COND_LE    = 3'd6,
        COND_NEVER = 3'd7
    } cond_e;

    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int NFLAGS = 2;
endpackage

// File: rtl/hwloop_cond.sv
// Termination test for the innermost loop.
// Combinational. Assumes flags are valid in the cycle the end address is fetched.
module hwloop_cond
    import hwloop_pkg::*;
(
    input  cond_e             cond,
    input  logic [NFLAGS-1:0] flags,
    input  logic              cnt_last,
    output logic              term
);
    logic z, n;
    assign z = flags[FLAG_Z];
    assign n = flags[FLAG_N];

    // Decode the condition code against the flags or the count state.
    always_comb begin
        unique case (cond)
            COND_LCE:   term = cnt_last;
            COND_EQ:    term = z;
            COND_NE:    term = !z;
            COND_LT:    term = n;
            COND_GE:    term = !n;
            COND_GT:    term = !n && !z;
            COND_LE:    term = n || z;
            default:    term = 1'b0;
        endcase
    end
endmodule

// File: rtl/hwloop_stack.sv
// Loop stack: one level per active loop, holding top, end, condition and saved outer count.
// Assumes push and pop are never requested together and push is never requested when full.
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 16,
    parameter int CW    = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [AW-1:0]  push_top,
    input  logic [AW-1:0]  push_end,
    input  cond_e          push_cond,
    input  logic [CW-1:0]  push_save,
    output logic [AW-1:0]  tos_top,
    output logic [AW-1:0]  tos_end,
    output cond_e          tos_cond,
    output logic [CW-1:0]  tos_save,
    output logic [SPW-1:0] sp,
    output logic           empty,
    output logic           full
);
    logic [AW-1:0] top_q  [DEPTH];
    logic [AW-1:0] end_q  [DEPTH];
    cond_e         cond_q [DEPTH];
    logic [CW-1:0] save_q [DEPTH];
    logic [SPW-1:0] tos_idx;

    assign empty   = (sp == '0);
    assign full    = (sp == SPW'(DEPTH));
    assign tos_idx = empty ? '0 : sp - 1'b1;

    // Stack pointer: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= sp + 1'b1;
        else if (pop)  sp <= sp - 1'b1;
    end

    // Entry storage; each level is written only when it is the push slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                top_q[g]  <= '0;
                end_q[g]  <= '0;
                cond_q[g] <= COND_LCE;
                save_q[g] <= '0;
            end else if (push && sp == SPW'(g)) begin
                top_q[g]  <= push_top;
                end_q[g]  <= push_end;
                cond_q[g] <= push_cond;
                save_q[g] <= push_save;
            end
        end
    end

    // Read port for the innermost level.
    always_comb begin
        tos_top  = top_q[tos_idx];
        tos_end  = end_q[tos_idx];
        tos_cond = cond_q[tos_idx];
        tos_save = save_q[tos_idx];
    end

    // R8
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) sp <= SPW'(DEPTH));
    // R9
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);
    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |=> sp == $past(sp) + 1'b1);
    // R4
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/hwloop_count.sv
// Count registers: the pending count written by software, and the active count of the innermost loop.
// Assumes take and restore are mutually exclusive with each other and with dec.
module hwloop_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          take,
    input  logic          restore,
    input  logic [CW-1:0] restore_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] pend,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    assign last = (cnt <= ONE);

    // Pending count: holds the value for the next loop start.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= '0;
        else if (load) pend <= load_val;
    end

    // Active count: restore on exit, take pending on start, step on a repeat.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restore) cnt <= restore_val;
        else if (take)    cnt <= pend;
        else if (dec)     cnt <= cnt - ONE;
    end

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n) dec |=> cnt == $past(cnt) - ONE);
    // R4
    dec_above_one_chk: assert property (@(posedge clk) disable iff (!rst_n) dec |-> !last);
endmodule

// File: rtl/hwloop_ctrl.sv
// Zero-overhead hardware loop controller.
// Watches the fetch address, pushes a level on each loop-start command, and in the cycle the
// innermost end address is fetched evaluates termination and selects the next PC.
// Assumes the fetch stage applies pc_sel/pc_target combinationally to form the next address.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 16,
    parameter int CW    = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              start_cmd,
    input  logic [AW-1:0]     start_end,
    input  logic [2:0]        start_cond,
    input  logic              cnt_load,
    input  logic [CW-1:0]     cnt_value,
    input  logic [NFLAGS-1:0] flags,
    output logic              pc_sel,
    output logic [AW-1:0]     pc_target,
    output logic              loop_active,
    output logic [CW-1:0]     cur_count,
    output logic [SPW-1:0]    loop_depth,
    output logic              stk_empty,
    output logic              stk_full,
    output logic              stk_ovf
);
    logic [AW-1:0] tos_top, tos_end;
    cond_e         tos_cond;
    logic [CW-1:0] tos_save, pend;
    logic          at_end, term, cnt_last;
    logic          push, pop, dec, start_ok;

    // End-of-body detection and next-PC decision.
    always_comb begin
        at_end   = !stk_empty && (fetch_addr == tos_end);
        pc_sel   = at_end && !term;
        pop      = at_end && term;
        dec      = pc_sel && (tos_cond == COND_LCE);
        start_ok = start_cmd && !at_end;
        push     = start_ok && !stk_full;
    end

    assign pc_target   = tos_top;
    assign loop_active = !stk_empty;

    hwloop_cond u_cond (
        .cond     (tos_cond),
        .flags    (flags),
        .cnt_last (cnt_last),
        .term     (term)
    );

    hwloop_stack #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_top  (fetch_addr + 1'b1),
        .push_end  (start_end),
        .push_cond (cond_e'(start_cond)),
        .push_save (cur_count),
        .tos_top   (tos_top),
        .tos_end   (tos_end),
        .tos_cond  (tos_cond),
        .tos_save  (tos_save),
        .sp        (loop_depth),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    hwloop_count #(.CW(CW)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cnt_load),
        .load_val    (cnt_value),
        .take        (push),
        .restore     (pop),
        .restore_val (tos_save),
        .dec         (dec),
        .cnt         (cur_count),
        .pend        (pend),
        .last        (cnt_last)
    );

    // Sticky overflow: a start refused because every level is in use.
    always_ff @(posedge clk) begin
        if (!rst_n)                  stk_ovf <= 1'b0;
        else if (start_ok && stk_full) stk_ovf <= 1'b1;
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) stk_ovf |=> stk_ovf);
    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && stk_full) |=> stk_ovf && $stable(loop_depth) && $stable(cur_count));
    // R6
    redirect_active_chk: assert property (@(posedge clk) disable iff (!rst_n) pc_sel |-> loop_active);
    // R5
    flag_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel && tos_cond != COND_LCE) |=> $stable(cur_count));
    // R4
    exit_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> loop_depth == $past(loop_depth) - 1'b1);
    // R10
    end_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && start_cmd && term) |=> loop_depth == $past(loop_depth) - 1'b1);
endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;
    localparam int DEPTH = 6;
    localparam int AW    = 16;
    localparam int CW    = 16;
    localparam int SPW   = $clog2(DEPTH + 1);
    localparam int PMEM  = 64;

    localparam int K_NOP = 0, K_LOAD = 1, K_START = 2, K_HALT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic start_cmd = 1'b0;
    logic [AW-1:0] start_end = '0;
    logic [2:0] start_cond = '0;
    logic cnt_load = 1'b0;
    logic [CW-1:0] cnt_value = '0;
    logic [1:0] flags = '0;
    logic pc_sel, loop_active, stk_empty, stk_full, stk_ovf;
    logic [AW-1:0] pc_target;
    logic [CW-1:0] cur_count;
    logic [SPW-1:0] loop_depth;

    always #2.5 clk = ~clk;

    hwloop_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_hwloop_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .start_cmd(start_cmd),
        .start_end(start_end), .start_cond(start_cond), .cnt_load(cnt_load),
        .cnt_value(cnt_value), .flags(flags), .pc_sel(pc_sel), .pc_target(pc_target),
        .loop_active(loop_active), .cur_count(cur_count), .loop_depth(loop_depth),
        .stk_empty(stk_empty), .stk_full(stk_full), .stk_ovf(stk_ovf)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // program memory
    int p_kind [PMEM];
    int p_val  [PMEM];
    int p_end  [PMEM];
    int p_cond [PMEM];
    int hits   [PMEM];
    int flag_mode = 0;

    // reference model
    int m_sp, m_cnt, m_pend, m_ovf;
    int m_top [DEPTH];
    int m_endv[DEPTH];
    int m_cnd [DEPTH];
    int m_save[DEPTH];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit eval_term(input int c, input int f, input int cnt);
        bit z = f[0];
        bit n = f[1];
        case (c)
            0: return cnt <= 1;
            1: return z;
            2: return !z;
            3: return n;
            4: return !n;
            5: return !n && !z;
            6: return n || z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_sp = 0; m_cnt = 0; m_pend = 0; m_ovf = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_cmd = 0; cnt_load = 0; flags = 0; fetch_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PMEM; i++) begin
            p_kind[i] = K_NOP; p_val[i] = 0; p_end[i] = 0; p_cond[i] = 0; hits[i] = 0;
        end
    endtask

    // Runs the program from address 0; the bench PC follows the model's expected redirect.
    task automatic run_prog(input int max_cyc);
        int pc = 0;
        int n = 0;
        bit done = 0;
        while (!done) begin
            int k, f, c_top;
            bit at_end, term, exp_sel, start_ok;
            string tag;
            @(negedge clk);
            k = p_kind[pc];
            f = (flag_mode != 0) ? (($urandom % 4 == 0) ? 1 : 0) | ((($urandom % 2) != 0) ? 2 : 0) : 0;
            fetch_addr = AW'(pc);
            start_cmd  = (k == K_START);
            start_end  = AW'(p_end[pc]);
            start_cond = 3'(p_cond[pc]);
            cnt_load   = (k == K_LOAD);
            cnt_value  = CW'(p_val[pc]);
            flags      = 2'(f);
            hits[pc]++;
            #1;
            c_top  = m_sp - 1;
            at_end = (m_sp > 0) && (pc == m_endv[c_top]);
            term   = at_end && eval_term(m_cnd[c_top], f, m_cnt);
            exp_sel = at_end && !term;
            if (!at_end) tag = "R6";
            else if (m_cnd[c_top] != 0) tag = "R5";
            else if (m_cnt <= 1) tag = "R4";
            else tag = "R3";
            chk(pc_sel == exp_sel, tag, "pc_sel", pc_sel, exp_sel);
            if (exp_sel) chk(pc_target == AW'(m_top[c_top]), tag, "pc_target", pc_target, m_top[c_top]);
            chk(cur_count == CW'(m_cnt), "R3", "cur_count", cur_count, m_cnt);
            chk(loop_depth == SPW'(m_sp), "R2", "loop_depth", loop_depth, m_sp);
            chk(loop_active == (m_sp > 0), "R2", "loop_active", loop_active, m_sp > 0);
            chk(stk_full == (m_sp == DEPTH), "R8", "stk_full", stk_full, m_sp == DEPTH);
            chk(stk_empty == (m_sp == 0), "R8", "stk_empty", stk_empty, m_sp == 0);
            chk(stk_ovf == m_ovf[0], "R9", "stk_ovf", stk_ovf, m_ovf);
            if (k == K_HALT) begin
                done = 1;
            end else begin
                // model update for the coming edge
                start_ok = (k == K_START) && !at_end;
                if (at_end && term) begin
                    m_cnt = m_save[c_top];
                    m_sp--;
                end else if (exp_sel && m_cnd[c_top] == 0) begin
                    m_cnt--;
                end else if (start_ok) begin
                    if (m_sp == DEPTH) m_ovf = 1;
                    else begin
                        m_top[m_sp]  = pc + 1;
                        m_endv[m_sp] = p_end[pc];
                        m_cnd[m_sp]  = p_cond[pc];
                        m_save[m_sp] = m_cnt;
                        m_cnt = m_pend;
                        m_sp++;
                    end
                end
                if (k == K_LOAD) m_pend = p_val[pc];
                pc = exp_sel ? m_top[c_top] : pc + 1;
                n++;
                if (n >= max_cyc) begin
                    chk(1'b0, "R6", "program did not reach halt", n, max_cyc);
                    done = 1;
                end
            end
        end
        @(negedge clk);
        start_cmd = 0; cnt_load = 0; flags = 0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 reset state
        do_reset();
        #1;
        chk(stk_empty == 1, "R1", "stk_empty", stk_empty, 1);
        chk(stk_full == 0, "R1", "stk_full", stk_full, 0);
        chk(loop_depth == 0, "R1", "loop_depth", loop_depth, 0);
        chk(stk_ovf == 0, "R1", "stk_ovf", stk_ovf, 0);
        chk(loop_active == 0, "R1", "loop_active", loop_active, 0);
        chk(pc_sel == 0, "R1", "pc_sel", pc_sel, 0);
        chk(cur_count == 0, "R1", "cur_count", cur_count, 0);

        // R7: count 30, three-instruction body
        clear_prog();
        p_kind[0] = K_LOAD; p_val[0] = 30;
        p_kind[1] = K_START; p_end[1] = 4; p_cond[1] = 0;
        p_kind[5] = K_HALT;
        run_prog(1000);
        chk(hits[2] == 30 && hits[4] == 30, "R7", "body passes", hits[4], 30);
        chk(hits[5] == 1, "R7", "fall-through reached", hits[5], 1);

        // R4: counts 0 and 1 run once
        for (int c = 0; c < 2; c++) begin
            do_reset();
            clear_prog();
            p_kind[0] = K_LOAD; p_val[0] = c;
            p_kind[1] = K_START; p_end[1] = 3;
            p_kind[4] = K_HALT;
            run_prog(100);
            chk(hits[3] == 1, "R4", "single pass", hits[3], 1);
        end

        // R3 / R4: random counts and body lengths
        for (int t = 0; t < 20; t++) begin
            int c = $urandom % 9;
            int b = 1 + $urandom % 4;
            do_reset();
            clear_prog();
            p_kind[0] = K_LOAD; p_val[0] = c;
            p_kind[1] = K_START; p_end[1] = 1 + b;
            p_kind[2 + b] = K_HALT;
            run_prog(200);
            chk(hits[1 + b] == ((c == 0) ? 1 : c), "R3", "random loop passes", hits[1 + b], (c == 0) ? 1 : c);
        end

        // R5: flag-terminated loops, each code, random flags
        for (int cd = 1; cd < 7; cd++) begin
            do_reset();
            clear_prog();
            flag_mode = 1;
            p_kind[0] = K_LOAD; p_val[0] = 7;
            p_kind[1] = K_START; p_end[1] = 4; p_cond[1] = cd;
            p_kind[5] = K_HALT;
            run_prog(2000);
            flag_mode = 0;
            chk(hits[5] == 1, "R5", "flag loop exit", hits[5], 1);
        end

        // R8: nesting, inner loop runs fully each outer pass
        do_reset();
        clear_prog();
        p_kind[0] = K_LOAD; p_val[0] = 3;
        p_kind[1] = K_START; p_end[1] = 7;
        p_kind[2] = K_LOAD; p_val[2] = 4;
        p_kind[3] = K_START; p_end[3] = 5;
        p_kind[8] = K_HALT;
        run_prog(500);
        chk(hits[5] == 12, "R8", "inner passes", hits[5], 12);
        chk(hits[7] == 3, "R8", "outer passes", hits[7], 3);

        // R9: seven nested starts on a six-level stack
        do_reset();
        clear_prog();
        for (int i = 0; i < 7; i++) begin
            p_kind[2*i] = K_LOAD; p_val[2*i] = 2;
            p_kind[2*i+1] = K_START; p_end[2*i+1] = 30 - i;
        end
        p_kind[31] = K_HALT;
        run_prog(20000);
        chk(stk_ovf == 1, "R9", "overflow sticky at end", stk_ovf, 1);
        chk(hits[25] == 64, "R9", "innermost held loop passes", hits[25], 64);

        // R10: start command placed at the end address
        do_reset();
        clear_prog();
        p_kind[0] = K_LOAD; p_val[0] = 3;
        p_kind[1] = K_START; p_end[1] = 3;
        p_kind[3] = K_START; p_end[3] = 9;
        p_kind[4] = K_HALT;
        run_prog(100);
        chk(hits[3] == 3, "R10", "end handling only", hits[3], 3);
        chk(loop_depth == 0, "R10", "depth after exit", loop_depth, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule